// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Frame Timer

This block derives the serial clock and chip-select framing of a SPI master from a faster core clock. A single start pulse from the sequencer opens a frame. Chip-select goes active and waits a programmed setup time. The block then clocks out a programmed number of bit periods, waits a programmed hold time and releases chip-select. It keeps chip-select inactive for a programmed gap before it reports completion with a one-cycle done pulse.

Every duration is written as a core-cycle count minus one. The high and low times of SCK are set separately, so one bit period lasts high + low + 2 core cycles. Clock polarity, clock phase and chip-select polarity are programmable. The block gives the shift engine a one-cycle launch strobe on each launch edge and a one-cycle sample strobe on each sample edge. A select bit moves sampling to the opposite edge type. A 3-bit delay field postpones the sample strobe by up to seven core cycles.

All settings are captured when a start is accepted. This includes the two bit-order flags, which the block only holds stable for the shift engine. Writes during a frame therefore take effect from the next frame.

The controller has six states:
- ST_IDLE: waiting for a start.
- ST_SETUP: chip-select is active and SCK rests.
- ST_LVL_REST: SCK is at its rest level for the first part of a bit.
- ST_LVL_ACT: SCK is at its active level for the second part of a bit.
- ST_HOLD: chip-select is still active after the last bit.
- ST_GAP: chip-select is inactive during the minimum gap.

The transitions are:
- T_GO: ST_IDLE to ST_SETUP when start is high.
- T_FIRST: ST_SETUP to ST_LVL_REST.
- T_LEAD: ST_LVL_REST to ST_LVL_ACT.
- T_NEXT: ST_LVL_ACT to ST_LVL_REST while bits remain.
- T_LAST: ST_LVL_ACT to ST_HOLD after the last bit.
- T_OFF: ST_HOLD to ST_GAP.
- T_END: ST_GAP to ST_IDLE, which raises done.

Every timed state moves on when its counter reaches zero.

Top module: `sck_frame_timer`

## Requirements
- R1: A start seen while the block is idle raises busy in the next cycle. The frame then lasts (setup+1) + (nbits_m1+1)·((hi+1)+(lo+1)) + (hold+1) + (gap+1) cycles with busy high.
- R2: SCK rests at the captured polarity level (0 or 1) outside the bit periods. In each bit it first spends the rest-level count and then the active-level count, with the high level lasting hi+1 cycles and the low level lo+1 cycles.
- R3: The chip-select pin is active from the first setup cycle through the last hold cycle and inactive during the gap. The polarity bit selects the active level: 1 means active high, 0 means active low.
- R4: The launch strobe pulses once per bit. With phase 0 it pulses in the first cycle of each bit. With phase 1 it pulses in the first active-level cycle, which is the leading edge.
- R5: With the select bit at 0, the sample strobe marks the leading edge for phase 0 and the trailing edge for phase 1. With the select bit at 1, it marks the other edge type. The trailing edge of a bit is the first cycle after its active level, including the first hold cycle.
- R6: The 3-bit delay value d (0 to 7) moves every sample strobe d cycles later.
- R7: done is high for exactly one cycle, the first idle cycle after the gap ends, and busy is low in that cycle.
- R8: All counts, modes and the two bit-order flags are captured when a start is accepted. Input changes during a frame leave the frame and the bit-order outputs unchanged.
- R9: A start while busy is ignored. A start held high opens the next frame in the cycle after done.
- R10: While reset is held, SCK is 0, the chip-select pin is 1, and the strobes, busy and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a frame when idle |
| nbits_m1 | input | BITS_W | Bits per frame minus one |
| sck_hi_m1 | input | CNT_W | SCK high time minus one |
| sck_lo_m1 | input | CNT_W | SCK low time minus one |
| cs_setup_m1 | input | CNT_W | CS setup time minus one |
| cs_hold_m1 | input | CNT_W | CS hold time minus one |
| cs_gap_m1 | input | GAP_W | CS inactive gap minus one |
| cpol | input | 1 | SCK rest level |
| cpha | input | 1 | 0: launch at bit start, sample leading; 1: launch leading, sample trailing |
| cs_act_high | input | 1 | 1: chip-select active high |
| samp_alt | input | 1 | Sample on the opposite edge type |
| samp_dly | input | DLY_W | Extra sample delay in core cycles |
| tx_msb_first | input | 1 | Transmit bit order request |
| rx_msb_first | input | 1 | Receive bit order request |
| sck | output | 1 | Serial clock |
| cs_pin | output | 1 | Chip-select pin level |
| launch_stb | output | 1 | Launch strobe to the shift engine |
| sample_stb | output | 1 | Sample strobe to the shift engine |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Frame complete pulse |
| tx_msb_q | output | 1 | Captured transmit bit order |
| rx_msb_q | output | 1 | Captured receive bit order |

## Verification
The bench drives the zero-length corner, where setup, hold, gap and the high time are all one cycle and the frame has a single bit. A design that skipped a state when its count is zero would shorten SCK or drop the trailing-edge sample that falls in the first hold cycle.

Every combination of phase and sample-select is exercised, together with delays of 0, 2, 3 and 7. Swapping the leading and trailing roles, or counting the delay from the wrong cycle, shifts the sample strobe off its expected cycle.

A mid-frame rewrite of every input plus a stray start catches a block that reads live settings or restarts. Start held high across done checks that frames run back to back with no lost cycle.

// File: rtl/sft_pkg.sv
package sft_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SETUP    = 3'd1,
        ST_LVL_REST = 3'd2,
        ST_LVL_ACT  = 3'd3,
        ST_HOLD     = 3'd4,
        ST_GAP      = 3'd5
    } sft_state_e;

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic cs_high;
        logic samp_alt;
        logic tx_msb;
        logic rx_msb;
    } sft_flags_t;

endpackage

// File: rtl/sft_cfg_capture.sv
module sft_cfg_capture
    import sft_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int GAP_W  = 8,
    parameter int BITS_W = 8,
    parameter int DLY_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BITS_W-1:0] nbits_d,
    input  logic [CNT_W-1:0]  hi_d,
    input  logic [CNT_W-1:0]  lo_d,
    input  logic [CNT_W-1:0]  hold_d,
    input  logic [GAP_W-1:0]  gap_d,
    input  logic [DLY_W-1:0]  dly_d,
    input  sft_flags_t        flags_d,
    output logic [BITS_W-1:0] nbits_q,
    output logic [CNT_W-1:0]  hi_q,
    output logic [CNT_W-1:0]  lo_q,
    output logic [CNT_W-1:0]  hold_q,
    output logic [GAP_W-1:0]  gap_q,
    output logic [DLY_W-1:0]  dly_q,
    output sft_flags_t        flags_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nbits_q <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
            hold_q  <= '0;
            gap_q   <= '0;
            dly_q   <= '0;
            flags_q <= '0;
        end else if (load) begin
            nbits_q <= nbits_d;
            hi_q    <= hi_d;
            lo_q    <= lo_d;
            hold_q  <= hold_d;
            gap_q   <= gap_d;
            dly_q   <= dly_d;
            flags_q <= flags_d;
        end
    end

endmodule

// File: rtl/sft_down_counter.sv
module sft_down_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/sft_sample_delay.sv
module sft_sample_delay #(
    parameter int DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_in,
    input  logic [DLY_W-1:0] sel,
    output logic             strobe_out
);

    localparam int TAPS = 1 << DLY_W;

    logic [TAPS-1:1] line_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
        end else begin
            line_q[1] <= strobe_in;
            for (int k = 2; k < TAPS; k++) begin
                line_q[k] <= line_q[k-1];
            end
        end
    end

    always_comb begin
        if (sel == '0) begin
            strobe_out = strobe_in;
        end else begin
            strobe_out = line_q[sel];
        end
    end

endmodule

// File: rtl/sck_frame_timer.sv
module sck_frame_timer
    import sft_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int GAP_W  = 8,
    parameter int BITS_W = 8,
    parameter int DLY_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BITS_W-1:0] nbits_m1,
    input  logic [CNT_W-1:0]  sck_hi_m1,
    input  logic [CNT_W-1:0]  sck_lo_m1,
    input  logic [CNT_W-1:0]  cs_setup_m1,
    input  logic [CNT_W-1:0]  cs_hold_m1,
    input  logic [GAP_W-1:0]  cs_gap_m1,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              cs_act_high,
    input  logic              samp_alt,
    input  logic [DLY_W-1:0]  samp_dly,
    input  logic              tx_msb_first,
    input  logic              rx_msb_first,
    output logic              sck,
    output logic              cs_pin,
    output logic              launch_stb,
    output logic              sample_stb,
    output logic              busy,
    output logic              done,
    output logic              tx_msb_q,
    output logic              rx_msb_q
);

    sft_state_e state_q, state_d;
    logic       first_q;
    logic       done_q, done_d;

    logic              cap_load;
    sft_flags_t        flags_in, flags_q;
    logic [BITS_W-1:0] nbits_q;
    logic [CNT_W-1:0]  hi_q, lo_q, hold_q;
    logic [GAP_W-1:0]  gap_q;
    logic [DLY_W-1:0]  dly_q;

    logic              ph_load;
    logic [CNT_W-1:0]  ph_val, ph_cnt;
    logic              ph_zero;
    logic              bit_load, bit_dec;
    logic [BITS_W-1:0] bit_cnt;
    logic              bit_zero;

    logic [CNT_W-1:0]  rest_cnt, act_cnt;
    logic              cs_on, cpol_q;
    logic              lead_evt, trail_evt, bit_start, samp_raw;

    // configuration capture
    assign cap_load = (state_q == ST_IDLE) && start;

    always_comb begin
        flags_in.cpol     = cpol;
        flags_in.cpha     = cpha;
        flags_in.cs_high  = cs_act_high;
        flags_in.samp_alt = samp_alt;
        flags_in.tx_msb   = tx_msb_first;
        flags_in.rx_msb   = rx_msb_first;
    end

    sft_cfg_capture #(
        .CNT_W (CNT_W),
        .GAP_W (GAP_W),
        .BITS_W(BITS_W),
        .DLY_W (DLY_W)
    ) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cap_load),
        .nbits_d(nbits_m1),
        .hi_d   (sck_hi_m1),
        .lo_d   (sck_lo_m1),
        .hold_d (cs_hold_m1),
        .gap_d  (cs_gap_m1),
        .dly_d  (samp_dly),
        .flags_d(flags_in),
        .nbits_q(nbits_q),
        .hi_q   (hi_q),
        .lo_q   (lo_q),
        .hold_q (hold_q),
        .gap_q  (gap_q),
        .dly_q  (dly_q),
        .flags_q(flags_q)
    );

    // phase and bit counters
    sft_down_counter #(.W(CNT_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ph_load),
        .load_val(ph_val),
        .dec     (!ph_load),
        .cnt     (ph_cnt)
    );

    sft_down_counter #(.W(BITS_W)) u_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (bit_load),
        .load_val(nbits_q),
        .dec     (bit_dec),
        .cnt     (bit_cnt)
    );

    assign ph_zero  = (ph_cnt == '0);
    assign bit_zero = (bit_cnt == '0);
    assign cpol_q   = flags_q.cpol;
    assign rest_cnt = flags_q.cpol ? hi_q : lo_q;
    assign act_cnt  = flags_q.cpol ? lo_q : hi_q;

    // next-state logic
    always_comb begin
        state_d  = state_q;
        ph_load  = 1'b0;
        ph_val   = '0;
        bit_load = 1'b0;
        bit_dec  = 1'b0;
        done_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_SETUP;
                    ph_load = 1'b1;
                    ph_val  = cs_setup_m1;
                end
            end
            ST_SETUP: begin
                if (ph_zero) begin
                    state_d  = ST_LVL_REST;
                    ph_load  = 1'b1;
                    ph_val   = rest_cnt;
                    bit_load = 1'b1;
                end
            end
            ST_LVL_REST: begin
                if (ph_zero) begin
                    state_d = ST_LVL_ACT;
                    ph_load = 1'b1;
                    ph_val  = act_cnt;
                end
            end
            ST_LVL_ACT: begin
                if (ph_zero) begin
                    ph_load = 1'b1;
                    if (bit_zero) begin
                        state_d = ST_HOLD;
                        ph_val  = hold_q;
                    end else begin
                        state_d = ST_LVL_REST;
                        ph_val  = rest_cnt;
                        bit_dec = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (ph_zero) begin
                    state_d = ST_GAP;
                    ph_load = 1'b1;
                    ph_val  = CNT_W'(gap_q);
                end
            end
            ST_GAP: begin
                if (ph_zero) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            first_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            first_q <= (state_d != state_q);
            done_q  <= done_d;
        end
    end

    // outputs
    always_comb begin
        cs_on     = (state_q == ST_SETUP) || (state_q == ST_LVL_REST) ||
                    (state_q == ST_LVL_ACT) || (state_q == ST_HOLD);
        sck       = (state_q == ST_LVL_ACT) ? ~flags_q.cpol : flags_q.cpol;
        cs_pin    = cs_on ? flags_q.cs_high : ~flags_q.cs_high;
        bit_start = first_q && (state_q == ST_LVL_REST);
        lead_evt  = first_q && (state_q == ST_LVL_ACT);
        trail_evt = first_q && (((state_q == ST_LVL_REST) && (bit_cnt != nbits_q)) ||
                                (state_q == ST_HOLD));
        launch_stb = flags_q.cpha ? lead_evt : bit_start;
        samp_raw   = (flags_q.cpha == flags_q.samp_alt) ? lead_evt : trail_evt;
        busy       = (state_q != ST_IDLE);
        done       = done_q;
        tx_msb_q   = flags_q.tx_msb;
        rx_msb_q   = flags_q.rx_msb;
    end

    sft_sample_delay #(.DLY_W(DLY_W)) u_sdly (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_in (samp_raw),
        .sel       (dly_q),
        .strobe_out(sample_stb)
    );

endmodule

// File: rtl/sft_checker.sv
module sft_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic launch_stb,
    input logic sck,
    input logic cs_on,
    input logic cpol_q
);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R1
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R4
    launch_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch_stb |-> (busy && cs_on));

    // R2
    sck_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_on |-> (sck == cpol_q));

    // R9
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

endmodule

bind sck_frame_timer sft_checker u_sft_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .launch_stb(launch_stb),
    .sck       (sck),
    .cs_on     (cs_on),
    .cpol_q    (cpol_q)
);

// File: tb/tb_sck_frame_timer.sv
`timescale 1ns/1ps
module tb_sck_frame_timer;

    localparam int CNT_W  = 16;
    localparam int GAP_W  = 8;
    localparam int BITS_W = 8;
    localparam int DLY_W  = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [BITS_W-1:0] nbits_m1 = '0;
    logic [CNT_W-1:0]  sck_hi_m1 = '0, sck_lo_m1 = '0, cs_setup_m1 = '0, cs_hold_m1 = '0;
    logic [GAP_W-1:0]  cs_gap_m1 = '0;
    logic              cpol = 0, cpha = 0, cs_act_high = 0, samp_alt = 0;
    logic [DLY_W-1:0]  samp_dly = '0;
    logic              tx_msb_first = 0, rx_msb_first = 0;
    logic sck, cs_pin, launch_stb, sample_stb, busy, done, tx_msb_q, rx_msb_q;

    sck_frame_timer #(.CNT_W(CNT_W), .GAP_W(GAP_W), .BITS_W(BITS_W), .DLY_W(DLY_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .nbits_m1(nbits_m1),
        .sck_hi_m1(sck_hi_m1), .sck_lo_m1(sck_lo_m1), .cs_setup_m1(cs_setup_m1),
        .cs_hold_m1(cs_hold_m1), .cs_gap_m1(cs_gap_m1), .cpol(cpol), .cpha(cpha),
        .cs_act_high(cs_act_high), .samp_alt(samp_alt), .samp_dly(samp_dly),
        .tx_msb_first(tx_msb_first), .rx_msb_first(rx_msb_first),
        .sck(sck), .cs_pin(cs_pin), .launch_stb(launch_stb), .sample_stb(sample_stb),
        .busy(busy), .done(done), .tx_msb_q(tx_msb_q), .rx_msb_q(rx_msb_q));

    int cyc = 0;
    int idle_from = 0;
    int errors = 0;
    int checks = 0;
    bit a_busy[int];
    bit a_cs[int];
    bit a_sck[int];
    bit a_launch[int];
    bit a_samp[int];
    bit a_done[int];
    logic m_cpol = 0, m_cshi = 0, m_tx = 0, m_rx = 0;

    task automatic chk(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s cycle %0d: actual=%0b expected=%0b", tag, what, cyc, act, exp);
        end
    endtask

    // behavioural frame schedule built at the accepting edge
    task automatic plan(int c0);
        int s, la, lb, h, g, nb, t, lead, trail, d;
        logic alt_lead;
        s  = int'(cs_setup_m1) + 1;
        la = cpol ? int'(sck_hi_m1) + 1 : int'(sck_lo_m1) + 1;
        lb = cpol ? int'(sck_lo_m1) + 1 : int'(sck_hi_m1) + 1;
        h  = int'(cs_hold_m1) + 1;
        g  = int'(cs_gap_m1) + 1;
        nb = int'(nbits_m1) + 1;
        d  = int'(samp_dly);
        alt_lead = (cpha == samp_alt);
        m_cpol = cpol; m_cshi = cs_act_high; m_tx = tx_msb_first; m_rx = rx_msb_first;
        t = c0;
        for (int i = 0; i < s; i++) begin a_busy[t] = 1; a_cs[t] = 1; t++; end
        for (int b = 0; b < nb; b++) begin
            lead  = t + la;
            trail = t + la + lb;
            a_launch[cpha ? lead : t] = 1;
            a_samp[(alt_lead ? lead : trail) + d] = 1;
            for (int i = 0; i < la + lb; i++) begin a_busy[t+i] = 1; a_cs[t+i] = 1; end
            for (int i = 0; i < lb; i++) a_sck[lead+i] = 1;
            t = trail;
        end
        for (int i = 0; i < h; i++) begin a_busy[t] = 1; a_cs[t] = 1; t++; end
        for (int i = 0; i < g; i++) begin a_busy[t] = 1; t++; end
        a_done[t] = 1;
        idle_from = t;
    endtask

    always @(posedge clk) begin
        if (rst_n && start && (cyc >= idle_from)) plan(cyc + 1);
        cyc = cyc + 1;
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            // R10 reset state
            chk("R10", "sck", sck, 1'b0);
            chk("R10", "cs_pin", cs_pin, 1'b1);
            chk("R10", "launch", launch_stb, 1'b0);
            chk("R10", "sample", sample_stb, 1'b0);
            chk("R10", "busy", busy, 1'b0);
            chk("R10", "done", done, 1'b0);
        end else begin
            chk("R1", "busy", busy, a_busy.exists(cyc));
            chk("R2", "sck", sck, a_sck.exists(cyc) ? ~m_cpol : m_cpol);
            chk("R3", "cs_pin", cs_pin, a_cs.exists(cyc) ? m_cshi : ~m_cshi);
            chk("R4", "launch", launch_stb, a_launch.exists(cyc));
            chk("R5,R6", "sample", sample_stb, a_samp.exists(cyc));
            chk("R7", "done", done, a_done.exists(cyc));
            chk("R8", "tx_order", tx_msb_q, m_tx);
            chk("R8", "rx_order", rx_msb_q, m_rx);
        end
    end

    task automatic set_cfg(int nb, int hi, int lo, int su, int ho, int gp,
                           bit pol, bit pha, bit csh, bit alt, int dl, bit tx, bit rx);
        nbits_m1 = BITS_W'(nb); sck_hi_m1 = CNT_W'(hi); sck_lo_m1 = CNT_W'(lo);
        cs_setup_m1 = CNT_W'(su); cs_hold_m1 = CNT_W'(ho); cs_gap_m1 = GAP_W'(gp);
        cpol = pol; cpha = pha; cs_act_high = csh; samp_alt = alt;
        samp_dly = DLY_W'(dl); tx_msb_first = tx; rx_msb_first = rx;
    endtask

    task automatic wait_idle();
        while (cyc < idle_from) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    task automatic one_frame();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait_idle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2 R4 R5: phase 0, leading-edge sampling, active-low CS
        set_cfg(7, 1, 1, 2, 1, 3, 0, 0, 0, 0, 0, 1, 1);
        one_frame();

        // R4 R5 R6: phase 1, asymmetric SCK, delay 2
        set_cfg(4, 2, 0, 1, 2, 1, 0, 1, 0, 0, 2, 0, 1);
        one_frame();

        // R3 R5 R6: zero-length counts, single bit, rest high, alt edge, delay 7
        set_cfg(0, 0, 0, 0, 0, 0, 1, 0, 1, 1, 7, 1, 0);
        one_frame();

        // R8 R9: rewrite all inputs mid-frame and pulse start while busy
        set_cfg(5, 1, 3, 3, 0, 2, 1, 1, 0, 1, 3, 0, 0);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (6) @(negedge clk);
        set_cfg(2, 9, 9, 9, 9, 9, 0, 0, 1, 0, 3, 1, 1);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R9", "busy_after_stray_start", busy, 1'b1);
        chk("R8", "tx_order_mid_frame", tx_msb_q, 1'b0);
        wait_idle();

        // R9: start held high, frames run back to back
        set_cfg(1, 0, 1, 0, 1, 0, 0, 0, 0, 1, 1, 1, 0);
        @(negedge clk) start = 1'b1;
        repeat (40) @(negedge clk);
        start = 1'b0;
        wait_idle();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not end, actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule